// File: doc/BRIEF.md
# Four-Channel Buffered-Update PWM Generator

This block drives several pulse-width modulated outputs from one clock. Each channel has a period word and a high-time word, both counted in clock cycles. A simple word-addressed write/read port sets them. In each cycle of a channel, the output is high for the first high-time clocks and low for the remaining clocks, and one cycle lasts period clocks. The counters run directly on the port clock. There is no prescaler, and inverted polarity is not available.

Software writes land in a buffered (shadow) copy of each word. A running channel keeps its working copy unchanged until the current cycle ends. At that boundary it takes both words from the buffer together, so no cycle ever combines a new period with an old high time. A period of zero is the disable command: the channel finishes its current cycle and then holds its output low. A channel that is idle starts its first cycle at once when it receives a non-zero period, and does not wait for a boundary. Reads return the buffered values.

Top module: `pwm_multi_ch`

## Requirements
- R1: A synchronous active-high reset clears every buffered word, working copy and counter. While reset is held and after it, every output is low and every read returns zero.
- R2: Channel c has its high-time word at byte address 8*c and its period word at 8*c+4 (address bit 2 selects between them). A read presents the last written value of the addressed word on `rdata` one clock after the address is applied.
- R3: For a running channel with period P and high time H (0 < H < P), the output repeats a pattern of H clocks high followed by P-H clocks low.
- R4: If the words are rewritten during a cycle, that cycle completes with the old period and high time. The new pair takes effect from the next boundary, with both words applied together.
- R5: Writing zero to both words turns the channel off. After its current cycle completes, its output stays low.
- R6: When an idle channel (working period zero) receives a non-zero period, the output of that cycle's first clock appears on the second clock edge after the write edge, without waiting for any boundary.
- R7: If H >= P with P non-zero, the output stays high continuously.
- R8: If H is zero and P is non-zero, the output stays low continuously.
- R9: A write to an address that is not word aligned, or that lies at or above 8*NUM_CH, changes no register. A read of such an address returns zero.
- R10: Each channel runs independently: configuring one channel does not change the waveform of another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the port and all counters |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| addr | input | ADDR_W | Byte address for reads and writes |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data for the address of the previous clock |
| pwm_out | output | NUM_CH | One registered waveform output per channel |

## Verification
A working copy that is taken from the buffer too early shows up at the output as a cycle whose length or high time matches neither the old pair nor the new pair. The bench measures every cycle from rising edge to rising edge, so this error appears within one cycle of the rewrite. A counter that skips or misses its boundary changes the measured period on the very first cycle. A decode fault that aliases a bad address onto a real word shows up on the next readback of that word, one clock after the address is applied. An idle channel that fails to start, or a disabled channel that keeps running, appears within two clocks, or within one period, as an output level that differs from the expected one.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  // Word select inside one channel's 8-byte slot (address bit 2)
  typedef enum logic {
    WSEL_HIGH   = 1'b0,
    WSEL_PERIOD = 1'b1
  } word_sel_e;
endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [DATA_W-1:0]              wdata,
  output logic [DATA_W-1:0]              rdata,
  output logic [NUM_CH-1:0][DATA_W-1:0]  shd_hi,
  output logic [NUM_CH-1:0][DATA_W-1:0]  shd_per
);
  localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int MAP_BYTES = NUM_CH * 8;
  localparam logic [ADDR_W:0] MAP_END = (ADDR_W+1)'(MAP_BYTES);

  logic            addr_ok;
  logic [CH_W-1:0] ch_idx;
  word_sel_e       wsel;
  logic [DATA_W-1:0] rdata_q;

  assign addr_ok = (addr[1:0] == 2'b00) && ({1'b0, addr} < MAP_END);
  assign ch_idx  = addr[3 +: CH_W];
  assign wsel    = word_sel_e'(addr[2]);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    logic [DATA_W-1:0] hi_q, per_q;
    logic              hit;
    assign hit = wr_en && addr_ok && (ch_idx == CH_W'(g));
    always_ff @(posedge clk) begin
      if (rst) begin
        hi_q  <= '0;
        per_q <= '0;
      end else if (hit) begin
        if (wsel == WSEL_PERIOD) per_q <= wdata;
        else                     hi_q  <= wdata;
      end
    end
    assign shd_hi[g]  = hi_q;
    assign shd_per[g] = per_q;
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_q <= '0;
    else if (!addr_ok) rdata_q <= '0;
    else if (wsel == WSEL_PERIOD) rdata_q <= shd_per[ch_idx];
    else              rdata_q <= shd_hi[ch_idx];
  end
  assign rdata = rdata_q;

  // R9
  bad_wr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !addr_ok) |=> ($stable(shd_hi) && $stable(shd_per)));
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] shd_hi,
  input  logic [DATA_W-1:0] shd_per,
  output logic              pwm_o
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] act_per, act_hi, cnt;
  logic              running, at_end, pwm_q;

  assign running = (act_per != '0);
  assign at_end  = running && (cnt == act_per - ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_per <= '0;
      act_hi  <= '0;
      cnt     <= '0;
      pwm_q   <= 1'b0;
    end else begin
      if (!running || at_end) begin
        // idle start or period boundary: take both words together
        act_per <= shd_per;
        act_hi  <= shd_hi;
        cnt     <= '0;
      end else begin
        cnt <= cnt + ONE;
      end
      pwm_q <= running && (cnt < act_hi);
    end
  end
  assign pwm_o = pwm_q;

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    running |-> (cnt < act_per));
  // R4
  mid_cycle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (running && !at_end) |=> ($stable(act_per) && $stable(act_hi)));
  // R5
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !running |=> !pwm_q);
  // R7
  full_high_chk: assert property (@(posedge clk) disable iff (rst)
    (running && (act_hi >= act_per)) |=> pwm_q);
endmodule

// File: rtl/pwm_multi_ch.sv
module pwm_multi_ch #(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  logic [NUM_CH-1:0][DATA_W-1:0] shd_hi, shd_per;

  pwm_regfile #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .shd_hi(shd_hi), .shd_per(shd_per)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwm_channel #(.DATA_W(DATA_W)) i_ch (
      .clk(clk), .rst(rst), .shd_hi(shd_hi[g]), .shd_per(shd_per[g]),
      .pwm_o(pwm_out[g])
    );
  end
endmodule

// File: tb/test_pwm_multi_ch.sv
module test_pwm_multi_ch;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int NVEC = 6;
  // {channel, period, high, expected high length, expected cycle length}
  localparam int VEC [NVEC][5] = '{
    '{0, 10,  3,  3, 10},
    '{1,  7,  1,  1,  7},
    '{2, 16, 15, 15, 16},
    '{3,  5,  2,  2,  5},
    '{0,  2,  1,  1,  2},
    '{1, 33, 20, 20, 33}
  };

  logic        clk = 0, rst = 1, wr_en = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic [NCH-1:0] pwm_out;
  int checks = 0, failures = 0;

  int hcnt[NCH], pcnt[NCH], rises[NCH], last_hi[NCH], last_per[NCH];
  bit seen[NCH];
  logic prev[NCH];

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_multi_ch i_pwm_multi_ch (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pwm_out(pwm_out)
  );

  // cycle monitor: on each rising output edge, record the finished cycle
  initial for (int c = 0; c < NCH; c++) begin
    hcnt[c] = 0; pcnt[c] = 0; rises[c] = 0; last_hi[c] = 0;
    last_per[c] = 0; seen[c] = 0; prev[c] = 0;
  end
  always @(negedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (pwm_out[c] && !prev[c]) begin
        if (seen[c]) begin last_hi[c] = hcnt[c]; last_per[c] = pcnt[c]; end
        seen[c] = 1; rises[c]++; hcnt[c] = 1; pcnt[c] = 1;
      end else begin
        pcnt[c]++;
        if (pwm_out[c]) hcnt[c]++;
      end
      prev[c] = pwm_out[c];
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); wr_en = 1; addr = 8'(a); wdata = 32'(d);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk); addr = 8'(a);
    @(posedge clk);
    @(negedge clk); d = int'(rdata);
  endtask

  task automatic cfg(int ch, int per, int hi);
    wr(ch*8, hi);
    wr(ch*8 + 4, per);
  endtask

  task automatic wait_rises(int ch, int n);
    int r0 = rises[ch];
    while (rises[ch] < r0 + n) @(posedge clk);
  endtask

  task automatic idle_cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        finish_run();
      end
    end
  end

  initial begin
    int d, r0, ones, bad;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 outputs low in reset", int'(pwm_out), 0);
    rst = 0;
    rd(0, d); chk("R1 read zero after reset", d, 0);

    // R2 register map readback
    for (int c = 0; c < NCH; c++) begin
      wr(c*8, 32'h1000 + c);
      wr(c*8 + 4, 32'h2000 + c);
    end
    for (int c = 0; c < NCH; c++) begin
      rd(c*8, d);     chk("R2 high word readback", d, 32'h1000 + c);
      rd(c*8 + 4, d); chk("R2 period word readback", d, 32'h2000 + c);
    end

    // R9 bad addresses
    wr(8'h05, 32'hDEAD); wr(8'h20, 32'hBEEF); wr(8'h1E, 32'hCAFE);
    rd(8'h04, d); chk("R9 unaligned write ignored", d, 32'h2000);
    rd(8'h1C, d); chk("R9 near-end write ignored", d, 32'h2003);
    rd(8'h18, d); chk("R9 high word intact", d, 32'h1003);
    rd(8'h05, d); chk("R9 unaligned read zero", d, 0);
    rd(8'h20, d); chk("R9 out of range read zero", d, 0);

    // R1 reset while running
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk);
    chk("R1 outputs low under reset", int'(pwm_out), 0);
    rst = 0;
    rd(8'h04, d); chk("R1 period cleared by reset", d, 0);
    idle_cycles(3);
    chk("R1 outputs stay low after reset", int'(pwm_out), 0);

    // R3 vector table
    for (int v = 0; v < NVEC; v++) begin
      cfg(VEC[v][0], 0, 0);
      idle_cycles(80);
      cfg(VEC[v][0], VEC[v][1], VEC[v][2]);
      wait_rises(VEC[v][0], 2);
      chk("R3 high length", last_hi[VEC[v][0]], VEC[v][3]);
      chk("R3 cycle length", last_per[VEC[v][0]], VEC[v][4]);
    end

    // R6 idle start timing (channel 3 idle)
    cfg(3, 0, 0); idle_cycles(20);
    wr(8'h18, 4);
    wr(8'h1C, 9);       // returns on the negedge after the write edge
    @(negedge clk); chk("R6 still low one edge after write", int'(pwm_out[3]), 0);
    @(negedge clk); chk("R6 high two edges after write", int'(pwm_out[3]), 1);

    // R4 buffered update: ch0 at 10/3, rewrite to 20/5 mid-cycle
    cfg(0, 10, 3);
    wait_rises(0, 2);
    @(negedge clk);
    cfg(0, 20, 5);
    wait_rises(0, 1);
    chk("R4 running cycle keeps old high", last_hi[0], 3);
    chk("R4 running cycle keeps old period", last_per[0], 10);
    wait_rises(0, 1);
    chk("R4 new high from boundary", last_hi[0], 5);
    chk("R4 new period from boundary", last_per[0], 20);

    // R5 disable
    cfg(0, 0, 0);
    idle_cycles(40);
    r0 = rises[0]; ones = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); ones += int'(pwm_out[0]); end
    chk("R5 disabled output low", ones, 0);
    chk("R5 no new cycles", rises[0], r0);

    // R7 high >= period
    cfg(2, 8, 8); idle_cycles(40);
    bad = 0;
    for (int i = 0; i < 24; i++) begin @(negedge clk); bad += int'(!pwm_out[2]); end
    chk("R7 high equals period stays high", bad, 0);
    cfg(2, 8, 12); idle_cycles(20);
    bad = 0;
    for (int i = 0; i < 24; i++) begin @(negedge clk); bad += int'(!pwm_out[2]); end
    chk("R7 high above period stays high", bad, 0);

    // R8 zero high time
    cfg(2, 8, 0); idle_cycles(20);
    ones = 0;
    for (int i = 0; i < 24; i++) begin @(negedge clk); ones += int'(pwm_out[2]); end
    chk("R8 zero high stays low", ones, 0);

    // R10 all channels at once
    for (int c = 0; c < NCH; c++) cfg(c, 6 + 3*c, 2 + c);
    for (int c = 0; c < NCH; c++) begin
      wait_rises(c, 2);
      chk("R10 independent high", last_hi[c], 2 + c);
      chk("R10 independent period", last_per[c], 6 + 3*c);
    end
    finish_run();
  end
endmodule